// File: doc/BRIEF.md
# Audio Link Controller Front End with DMA Countdown

This block is the register-mapped front end of an audio codec link controller. It serves two kinds of traffic. The first is a codec register handshake: software fills in a codec register address and a data word, then writes a control word. That write fires a single-cycle interrupt toward the serial link logic, and the direction bit in the word selects which interrupt. The second kind is sample traffic on two DMA channels, one for playback and one for capture. Each channel has an enable, a memory byte address and a remaining-byte counter. Samples are stereo signed 16-bit at 48 kHz, so one 32-bit word holds one stereo sample and one memory beat moves one sample.

Playback channel: state `CH_IDLE` goes to `CH_MEM` when the channel is enabled and at least four bytes remain. `CH_MEM` goes to `CH_STREAM` on the memory acknowledge, and `CH_STREAM` returns to `CH_IDLE` once the sink takes the sample. Capture channel: `CH_IDLE` goes to `CH_MEM` when it accepts a sample from the source, and `CH_MEM` returns to `CH_IDLE` on the acknowledge. One memory master port is shared by both channels. It is arbitrated by a lock with states `ARB_FREE`, `ARB_DN` and `ARB_UP`. When the port is free, playback wins. Ownership passes to a requester and is held until that requester's beat is acknowledged, and then the lock returns to `ARB_FREE`.

Every acknowledged beat advances the channel address by 4 and lowers its remaining count by 4. When a beat brings the count to zero while the channel is enabled, the channel's completion interrupt pulses for one cycle. The serial link framing toward the codec sits outside this block.

Top module: `audlink_ctrl`

## Requirements
- R1: Word indices 1, 2, 3 (codec address, data out, data in), 4, 5, 6 (playback enable, address, remaining) and 8, 9, 10 (capture enable, address, remaining) read back the last value written to them. The word index is bus_addr[5:2].
- R2: Word index 7 and word indices 11 to 15 read as zero, and writes to them have no effect.
- R3: An access is valid only when bus_be is 4'hF and bus_addr[1:0] is 0. An invalid write changes nothing, and an invalid read returns zero.
- R4: Word index 0 (codec control) stores the written value with bit 0 forced to zero.
- R5: A valid write to word index 0 with bit 0 set raises irq_codec_req for exactly the next cycle if bit 1 is set, and otherwise raises irq_codec_rep for exactly the next cycle. A write with bit 0 clear raises neither.
- R6: When bit 0 of its control word is set and remaining is at least 4, the playback channel reads memory at its address and presents the word on play_sample with play_valid. It holds the word stable until play_ready. Each acknowledged beat adds 4 to the address and subtracts 4 from remaining.
- R7: When bit 0 of its control word is set and remaining is at least 4, the capture channel raises cap_ready. It takes cap_sample on cap_valid and writes it to memory at its address with mem_we set. Each acknowledged beat adds 4 to the address and subtracts 4 from remaining.
- R8: When an acknowledged beat brings an enabled channel's remaining count to zero, that channel's done interrupt (irq_play_done or irq_cap_done) is high for exactly one cycle, the cycle after the acknowledge.
- R9: A disabled channel, or one whose remaining count is below 4, issues no memory beat, takes no sample and produces no done pulse.
- R10: Reset clears every register, disables both channels and idles mem_req, play_valid, cap_ready and all interrupts.
- R11: Once mem_req is raised, mem_addr, mem_we and mem_wdata stay stable until mem_ack. The other channel waits for the port even while it has a request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte address |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | 1 = write (capture), 0 = read (playback) |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Capture sample being written |
| mem_ack | input | 1 | One-cycle beat acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| play_valid | output | 1 | Playback sample available |
| play_ready | input | 1 | Sink accepts the playback sample |
| play_sample | output | 32 | Stereo playback sample |
| cap_valid | input | 1 | Capture sample available |
| cap_ready | output | 1 | Block accepts a capture sample |
| cap_sample | input | 32 | Stereo capture sample |
| irq_codec_req | output | 1 | Codec write request pulse |
| irq_codec_rep | output | 1 | Codec read (reply) request pulse |
| irq_play_done | output | 1 | Playback countdown reached zero |
| irq_cap_done | output | 1 | Capture countdown reached zero |

## Verification
The assertions assume a memory responder that acknowledges only a pending request, with a single-cycle mem_ack. They also assume software does not reload a channel's remaining count in the very cycle that channel's beat completes. The bench memory model acknowledges one cycle after it sees a request, never twice in a row, and it can be stalled to hold a request open. The bench issues every register write while the affected channel is idle or disabled. It raises cap_valid only during the capture scenarios, so the capture side never sees a sample it was not meant to take.

// File: rtl/audlink_pkg.sv
package audlink_pkg;

    // Word indices of the register window; order is decoded by software.
    typedef enum logic [3:0] {
        RG_CODEC_CTL = 4'd0,
        RG_CODEC_ADR = 4'd1,
        RG_CODEC_DO  = 4'd2,
        RG_CODEC_DI  = 4'd3,
        RG_DN_CTL    = 4'd4,
        RG_DN_ADR    = 4'd5,
        RG_DN_REM    = 4'd6,
        RG_RSVD      = 4'd7,
        RG_UP_CTL    = 4'd8,
        RG_UP_ADR    = 4'd9,
        RG_UP_REM    = 4'd10
    } reg_idx_e;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_MEM    = 2'd1,
        CH_STREAM = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        ARB_FREE = 2'd0,
        ARB_DN   = 2'd1,
        ARB_UP   = 2'd2
    } arb_state_e;

    // Load strobe positions inside a channel's load vector.
    localparam int LD_CTL = 0;
    localparam int LD_ADR = 1;
    localparam int LD_REM = 2;

endpackage

// File: rtl/audlink_regs.sv
module audlink_regs
    import audlink_pkg::*;
#(
    parameter int BUS_AW = 6,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW/8-1:0]   bus_be,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_req,
    output logic              irq_rep,
    output logic [2:0]        dn_ld,
    output logic [2:0]        up_ld,
    input  logic [DW-1:0]     dn_ctl,
    input  logic [DW-1:0]     dn_adr,
    input  logic [DW-1:0]     dn_rem,
    input  logic [DW-1:0]     up_ctl,
    input  logic [DW-1:0]     up_adr,
    input  logic [DW-1:0]     up_rem
);

    localparam int IDX_W = BUS_AW - 2;

    logic             acc_ok;
    logic             wr_ok;
    logic             rd_ok;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    cc_q;
    logic [DW-1:0]    ca_q;
    logic [DW-1:0]    cdo_q;
    logic [DW-1:0]    cdi_q;

    assign idx    = bus_addr[BUS_AW-1:2];
    assign acc_ok = bus_sel && (bus_be == '1) && (bus_addr[1:0] == 2'b00);
    assign wr_ok  = acc_ok && bus_we;
    assign rd_ok  = acc_ok && !bus_we;

    function automatic logic hit(input logic [IDX_W-1:0] i, input reg_idx_e r);
        return i == IDX_W'(r);
    endfunction

    assign dn_ld[LD_CTL] = wr_ok && hit(idx, RG_DN_CTL);
    assign dn_ld[LD_ADR] = wr_ok && hit(idx, RG_DN_ADR);
    assign dn_ld[LD_REM] = wr_ok && hit(idx, RG_DN_REM);
    assign up_ld[LD_CTL] = wr_ok && hit(idx, RG_UP_CTL);
    assign up_ld[LD_ADR] = wr_ok && hit(idx, RG_UP_ADR);
    assign up_ld[LD_REM] = wr_ok && hit(idx, RG_UP_REM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q    <= '0;
            ca_q    <= '0;
            cdo_q   <= '0;
            cdi_q   <= '0;
            irq_req <= 1'b0;
            irq_rep <= 1'b0;
        end else begin
            irq_req <= 1'b0;
            irq_rep <= 1'b0;
            if (wr_ok && hit(idx, RG_CODEC_CTL)) begin
                // request-enable bit never sticks
                cc_q    <= {bus_wdata[DW-1:1], 1'b0};
                irq_req <= bus_wdata[0] && bus_wdata[1];
                irq_rep <= bus_wdata[0] && !bus_wdata[1];
            end
            if (wr_ok && hit(idx, RG_CODEC_ADR)) ca_q  <= bus_wdata;
            if (wr_ok && hit(idx, RG_CODEC_DO))  cdo_q <= bus_wdata;
            if (wr_ok && hit(idx, RG_CODEC_DI))  cdi_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (idx)
                IDX_W'(RG_CODEC_CTL): bus_rdata = cc_q;
                IDX_W'(RG_CODEC_ADR): bus_rdata = ca_q;
                IDX_W'(RG_CODEC_DO):  bus_rdata = cdo_q;
                IDX_W'(RG_CODEC_DI):  bus_rdata = cdi_q;
                IDX_W'(RG_DN_CTL):    bus_rdata = dn_ctl;
                IDX_W'(RG_DN_ADR):    bus_rdata = dn_adr;
                IDX_W'(RG_DN_REM):    bus_rdata = dn_rem;
                IDX_W'(RG_UP_CTL):    bus_rdata = up_ctl;
                IDX_W'(RG_UP_ADR):    bus_rdata = up_adr;
                IDX_W'(RG_UP_REM):    bus_rdata = up_rem;
                default:              bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/audlink_chan.sv
module audlink_chan
    import audlink_pkg::*;
#(
    parameter bit CAPTURE = 1'b0,
    parameter int DW      = 32,
    parameter int AW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    ld,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] ctl_q,
    output logic [AW-1:0] adr_q,
    output logic [DW-1:0] rem_q,
    output logic          m_req,
    input  logic          m_ack,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] sample_q,
    input  logic          xfer_ok,
    output logic          xfer_go,
    output logic          done_q
);

    localparam int STEP = DW / 8;

    ch_state_e state_q;
    ch_state_e state_n;
    logic      can_go;
    logic      beat_end;
    logic      take;

    assign can_go   = ctl_q[0] && (rem_q >= DW'(STEP));
    assign beat_end = (state_q == CH_MEM) && m_ack;

    generate
        if (CAPTURE) begin : g_cap
            always_comb begin
                state_n = state_q;
                xfer_go = (state_q == CH_IDLE) && can_go;
                take    = xfer_go && xfer_ok;
                unique case (state_q)
                    CH_IDLE: if (take)  state_n = CH_MEM;
                    CH_MEM:  if (m_ack) state_n = CH_IDLE;
                    default:            state_n = CH_IDLE;
                endcase
            end
        end else begin : g_play
            always_comb begin
                state_n = state_q;
                xfer_go = (state_q == CH_STREAM);
                take    = beat_end;
                unique case (state_q)
                    CH_IDLE:   if (can_go)  state_n = CH_MEM;
                    CH_MEM:    if (m_ack)   state_n = CH_STREAM;
                    CH_STREAM: if (xfer_ok) state_n = CH_IDLE;
                    default:                state_n = CH_IDLE;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_n;
    end

    assign m_req = (state_q == CH_MEM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            adr_q    <= '0;
            rem_q    <= '0;
            sample_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (ld[LD_CTL]) ctl_q <= ld_val;
            if (ld[LD_ADR])    adr_q <= AW'(ld_val);
            else if (beat_end) adr_q <= adr_q + AW'(STEP);
            if (ld[LD_REM])    rem_q <= ld_val;
            else if (beat_end) rem_q <= (rem_q >= DW'(STEP)) ? rem_q - DW'(STEP) : '0;
            if (take) sample_q <= in_data;
            done_q <= beat_end && !ld[LD_REM] && ctl_q[0] && (rem_q == DW'(STEP));
        end
    end

endmodule

// File: rtl/audlink_arb.sv
module audlink_arb
    import audlink_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dn_req,
    input  logic [AW-1:0] dn_addr,
    input  logic          up_req,
    input  logic [AW-1:0] up_addr,
    input  logic [DW-1:0] up_data,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          dn_ack,
    output logic          up_ack
);

    arb_state_e owner_q;
    arb_state_e owner_n;
    arb_state_e gsel;

    always_comb begin
        unique case (owner_q)
            ARB_DN:  gsel = ARB_DN;
            ARB_UP:  gsel = ARB_UP;
            default: gsel = dn_req ? ARB_DN : (up_req ? ARB_UP : ARB_FREE);
        endcase
        owner_n = (mem_req && !mem_ack) ? gsel : ARB_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= ARB_FREE;
        else        owner_q <= owner_n;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (gsel)
            ARB_DN: begin
                mem_req  = dn_req;
                mem_addr = dn_addr;
            end
            ARB_UP: begin
                mem_req   = up_req;
                mem_we    = 1'b1;
                mem_addr  = up_addr;
                mem_wdata = up_data;
            end
            default: ;
        endcase
        dn_ack = mem_ack && (gsel == ARB_DN);
        up_ack = mem_ack && (gsel == ARB_UP);
    end

endmodule

// File: rtl/audlink_ctrl.sv
module audlink_ctrl
    import audlink_pkg::*;
#(
    parameter int BUS_AW = 6,
    parameter int DW     = 32,
    parameter int AW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW/8-1:0]   bus_be,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              play_valid,
    input  logic              play_ready,
    output logic [DW-1:0]     play_sample,
    input  logic              cap_valid,
    output logic              cap_ready,
    input  logic [DW-1:0]     cap_sample,
    output logic              irq_codec_req,
    output logic              irq_codec_rep,
    output logic              irq_play_done,
    output logic              irq_cap_done
);

    logic [2:0]    dn_ld, up_ld;
    logic [DW-1:0] dn_ctl, dn_rem, up_ctl, up_rem;
    logic [AW-1:0] dn_adr, up_adr;
    logic [DW-1:0] up_smp;
    logic          dn_req, up_req, dn_ack, up_ack;

    audlink_regs #(.BUS_AW(BUS_AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_codec_req), .irq_rep(irq_codec_rep),
        .dn_ld(dn_ld), .up_ld(up_ld),
        .dn_ctl(dn_ctl), .dn_adr(DW'(dn_adr)), .dn_rem(dn_rem),
        .up_ctl(up_ctl), .up_adr(DW'(up_adr)), .up_rem(up_rem)
    );

    audlink_chan #(.CAPTURE(1'b0), .DW(DW), .AW(AW)) u_dn (
        .clk(clk), .rst_n(rst_n),
        .ld(dn_ld), .ld_val(bus_wdata),
        .ctl_q(dn_ctl), .adr_q(dn_adr), .rem_q(dn_rem),
        .m_req(dn_req), .m_ack(dn_ack),
        .in_data(mem_rdata), .sample_q(play_sample),
        .xfer_ok(play_ready), .xfer_go(play_valid),
        .done_q(irq_play_done)
    );

    audlink_chan #(.CAPTURE(1'b1), .DW(DW), .AW(AW)) u_up (
        .clk(clk), .rst_n(rst_n),
        .ld(up_ld), .ld_val(bus_wdata),
        .ctl_q(up_ctl), .adr_q(up_adr), .rem_q(up_rem),
        .m_req(up_req), .m_ack(up_ack),
        .in_data(cap_sample), .sample_q(up_smp),
        .xfer_ok(cap_valid), .xfer_go(cap_ready),
        .done_q(irq_cap_done)
    );

    audlink_arb #(.DW(DW), .AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .dn_req(dn_req), .dn_addr(dn_adr),
        .up_req(up_req), .up_addr(up_adr), .up_data(up_smp),
        .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata),
        .dn_ack(dn_ack), .up_ack(up_ack)
    );

endmodule

// File: rtl/audlink_chk.sv
module audlink_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [5:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        play_valid,
    input logic        play_ready,
    input logic [31:0] play_sample,
    input logic        irq_codec_req,
    input logic        irq_codec_rep,
    input logic        irq_play_done,
    input logic        irq_cap_done,
    input logic [31:0] dn_rem,
    input logic [31:0] up_rem
);

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_addr[5:2] == 4'd7 || bus_addr[5:2] > 4'd10)) |-> bus_rdata == '0); // R2

    AST_BAD_ACCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_be != 4'hF || bus_addr[1:0] != 2'b00)) |-> bus_rdata == '0); // R3

    AST_CTRL_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_be == 4'hF && bus_addr == 6'd0) |-> !bus_rdata[0]); // R4

    AST_CODEC_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_codec_req && irq_codec_rep)); // R5

    AST_CODEC_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_codec_req |-> $past(bus_sel && bus_we && bus_be == 4'hF && bus_addr == 6'd0 && bus_wdata[1:0] == 2'b11)); // R5

    AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (play_valid && !play_ready) |=> (play_valid && $stable(play_sample))); // R6

    AST_PLAY_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_play_done |-> dn_rem == '0); // R8

    AST_CAP_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cap_done |-> up_rem == '0); // R8

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

endmodule

bind audlink_ctrl audlink_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .play_valid(play_valid), .play_ready(play_ready), .play_sample(play_sample),
    .irq_codec_req(irq_codec_req), .irq_codec_rep(irq_codec_rep),
    .irq_play_done(irq_play_done), .irq_cap_done(irq_cap_done),
    .dn_rem(dn_rem), .up_rem(up_rem)
);

// File: tb/test_audlink_ctrl.sv
`timescale 1ns/1ps
module test_audlink_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        play_valid, play_ready = 1'b1;
    logic [31:0] play_sample;
    logic        cap_valid = 1'b0, cap_ready;
    logic [31:0] cap_sample;
    logic        irq_codec_req, irq_codec_rep, irq_play_done, irq_cap_done;

    int n_chk = 0, n_err = 0;
    int dn_done = 0, up_done = 0, beats = 0, cap_cnt = 0, play_n = 0;
    logic [31:0] play_log [8];
    logic [31:0] wmem [16];
    logic stall = 1'b0;
    logic finished = 1'b0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    audlink_ctrl i_audlink_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .play_valid(play_valid), .play_ready(play_ready), .play_sample(play_sample),
        .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_sample(cap_sample),
        .irq_codec_req(irq_codec_req), .irq_codec_rep(irq_codec_rep),
        .irq_play_done(irq_play_done), .irq_cap_done(irq_cap_done)
    );

    // memory responder, sink/source bookkeeping
    assign mem_rdata  = 32'h5A00_0000 | mem_addr;
    assign cap_sample = 32'hC0DE_0000 + cap_cnt;

    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack && !stall;
        if (mem_req && mem_ack) beats <= beats + 1;
        if (mem_req && mem_ack && mem_we) wmem[mem_addr[5:2]] <= mem_wdata;
        if (play_valid && play_ready) begin
            play_log[play_n[2:0]] <= play_sample;
            play_n <= play_n + 1;
        end
        if (cap_valid && cap_ready) cap_cnt <= cap_cnt + 1;
        if (irq_play_done) dn_done <= dn_done + 1;
        if (irq_cap_done)  up_done <= up_done + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wreg(input int idx, input logic [31:0] d);
        bus_write({idx[3:0], 2'b00}, 4'hF, d);
    endtask

    task automatic rreg(input int idx, output logic [31:0] d);
        bus_read({idx[3:0], 2'b00}, 4'hF, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {word index, byte enables, write data, expected readback, requirement}
    localparam int NV = 13;
    localparam logic [75:0] VEC [NV] = '{
        {4'd1,  4'hF, 32'h0000_1234, 32'h0000_1234, 4'd1},  // R1
        {4'd2,  4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd1},
        {4'd3,  4'hF, 32'h0BAD_F00D, 32'h0BAD_F00D, 4'd1},
        {4'd4,  4'hF, 32'h0000_0100, 32'h0000_0100, 4'd1},
        {4'd5,  4'hF, 32'h0000_0040, 32'h0000_0040, 4'd1},
        {4'd6,  4'hF, 32'h0000_0002, 32'h0000_0002, 4'd1},
        {4'd8,  4'hF, 32'h0000_0200, 32'h0000_0200, 4'd1},
        {4'd9,  4'hF, 32'h0000_0080, 32'h0000_0080, 4'd1},
        {4'd10, 4'hF, 32'h0000_0003, 32'h0000_0003, 4'd1},
        {4'd7,  4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 4'd2},  // R2
        {4'd13, 4'hF, 32'h1234_5678, 32'h0000_0000, 4'd2},
        {4'd0,  4'hF, 32'h0000_00F2, 32'h0000_00F2, 4'd4},  // R4
        {4'd1,  4'h3, 32'h0000_9999, 32'h0000_1234, 4'd3}   // R3
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R10: reset state
        for (int i = 0; i < 16; i++) begin
            rreg(i, rd);
            check("R10 reset word", rd, 32'h0);
        end
        check("R10 idle outputs", {28'h0, mem_req, play_valid, cap_ready, irq_codec_req},
              32'h0);

        // register table
        for (int v = 0; v < NV; v++) begin
            bus_write({VEC[v][75:72], 2'b00}, VEC[v][71:68], VEC[v][67:36]);
            rreg(int'(VEC[v][75:72]), rd);
            check($sformatf("R%0d table row %0d", VEC[v][3:0], v), rd, VEC[v][35:4]);
        end

        // R3: misaligned write ignored, partial-enable read returns zero
        bus_write(6'h05, 4'hF, 32'h0000_7777);
        rreg(1, rd);
        check("R3 misaligned write", rd, 32'h0000_1234);
        bus_read(6'h08, 4'h1, rd);
        check("R3 partial read", rd, 32'h0);

        // R5 / R4: codec request pulses
        wreg(0, 32'h3);
        check("R5 write pulse", {30'h0, irq_codec_req, irq_codec_rep}, 32'h2);
        idle(1);
        check("R5 pulse one cycle", {30'h0, irq_codec_req, irq_codec_rep}, 32'h0);
        rreg(0, rd);
        check("R4 bit0 cleared", rd, 32'h2);
        wreg(0, 32'h1);
        check("R5 reply pulse", {30'h0, irq_codec_req, irq_codec_rep}, 32'h1);
        wreg(0, 32'h2);
        check("R5 no pulse when bit0 clear", {30'h0, irq_codec_req, irq_codec_rep}, 32'h0);

        // R6 / R8: playback countdown of three beats
        wreg(5, 32'h10);
        wreg(6, 32'd12);
        wreg(4, 32'h1);
        idle(40);
        check("R6 beats streamed", play_n, 32'd3);
        check("R6 sample 0", play_log[0], 32'h5A00_0010);
        check("R6 sample 1", play_log[1], 32'h5A00_0014);
        check("R6 sample 2", play_log[2], 32'h5A00_0018);
        rreg(5, rd); check("R6 address advanced", rd, 32'h1C);
        rreg(6, rd); check("R6 remaining zero", rd, 32'h0);
        check("R8 playback done once", dn_done, 32'd1);

        // R7 / R8: capture countdown of two beats
        cap_valid = 1'b1;
        wreg(9, 32'h20);
        wreg(10, 32'd8);
        wreg(8, 32'h1);
        idle(40);
        cap_valid = 1'b0;
        check("R7 word 8", wmem[8], 32'hC0DE_0000);
        check("R7 word 9", wmem[9], 32'hC0DE_0001);
        check("R7 samples taken", cap_cnt, 32'd2);
        rreg(9, rd);  check("R7 address advanced", rd, 32'h28);
        rreg(10, rd); check("R7 remaining zero", rd, 32'h0);
        check("R8 capture done once", up_done, 32'd1);

        // R9: short count and disabled channel move nothing
        wreg(6, 32'd2);
        wreg(8, 32'h0);
        wreg(10, 32'd8);
        cap_valid = 1'b1;
        idle(20);
        check("R9 no capture handshake", cap_ready, 1'b0);
        cap_valid = 1'b0;
        check("R9 no beats", beats, 32'd5);
        rreg(6, rd);  check("R9 short count kept", rd, 32'd2);
        rreg(10, rd); check("R9 disabled count kept", rd, 32'd8);
        check("R9 no done pulses", dn_done + up_done, 32'd2);
        check("R9 no samples", cap_cnt, 32'd2);

        // R11: playback holds the port while capture waits
        stall = 1'b1;
        wreg(5, 32'h08);
        wreg(6, 32'd4);
        cap_valid = 1'b1;
        wreg(9, 32'h30);
        wreg(10, 32'd4);
        wreg(8, 32'h1);
        idle(6);
        check("R11 port held req", mem_req, 1'b1);
        check("R11 port held dir", mem_we, 1'b0);
        check("R11 port held addr", mem_addr, 32'h08);
        check("R7 capture waiting", cap_cnt, 32'd3);
        cap_valid = 1'b0;
        stall = 1'b0;
        idle(20);
        check("R11 playback served", play_log[3], 32'h5A00_0008);
        check("R11 capture served", wmem[12], 32'hC0DE_0002);
        check("R8 both done", {16'(dn_done), 16'(up_done)}, {16'd2, 16'd2});

        // R10: reset mid-run clears state
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rreg(1, rd);  check("R10 codec address cleared", rd, 32'h0);
        rreg(4, rd);  check("R10 playback disabled", rd, 32'h0);
        rreg(9, rd);  check("R10 capture address cleared", rd, 32'h0);
        rreg(10, rd); check("R10 capture count cleared", rd, 32'h0);
        check("R10 outputs idle", {29'h0, mem_req, play_valid, cap_ready}, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule